// File: doc/BRIEF.md
# Four-Channel Reloadable Down-Counter Timer Bank

This block holds four down-counting timer channels that sit beside an interrupt controller. All channels advance on a shared step that a prescaler derives from the bus clock. Each channel counts down from a reload value. When it is stepped at a count of zero, it reloads, flips a toggle flag and issues a one-cycle interrupt request, unless that channel's mask bit is set.

Software reaches the block through a simple word-addressed bus. The bus has a write strobe, a word address and combinational read data. Each channel has a base register, which holds the run/stop flag and the reload value, and a read-only count register. A shared control register sets the channel chaining, the rollover choice, the masks and the step ratio. A free-storage frequency register only holds a value for software to read back.

A channel can be chained behind its lower neighbour. It then advances on the neighbour's zero events instead of the shared step. This builds wider or slower timers.

Top module: `tmr_bank`

## Requirements
- R1: After reset the four base registers read 0x00000001, with the stop flag set and a base value of 0. The count, control and frequency registers read 0, and every interrupt line is low.
- R2: The register map uses word addresses. Addresses 0-3 are the base registers of channels 0-3, laid out as {base[31:1], stop[0]}. Addresses 4-7 are the count registers, laid out as {count[31:1], toggle[0]}; they are read-only and ignore writes. Address 8 is control and address 9 is frequency. Every other address reads 0.
- R3: While a channel's stop flag is 0, its count falls by one on each step it receives. While the flag is 1, the count and the toggle flag hold.
- R4: When a stop flag changes from 1 to 0, the channel loads its base value into the count and clears its toggle flag on the next clock edge. No step is taken on that edge.
- R5: A step that arrives while the count is 0 is a zero event. It reloads the count, inverts the toggle flag and raises the interrupt line for exactly the following cycle. A base value B therefore gives one event every B+1 steps, and B = 0 gives one event on every step.
- R6: Control bits [15:8] hold a ratio R, and the shared step fires every R+1 clock cycles. A write to control restarts the prescaler phase, so after a control write committed on edge C, steps land on edges C + k(R+1) for k >= 1.
- R7: Control bit i (i = 0..2) chains channel i+1 behind channel i. Channel i+1 then steps on channel i's zero events instead of the shared step.
- R8: A chained channel reloads all ones (count field 0x7FFFFFFF) when control bit 3 is 1, and reloads its base value when that bit is 0. An unchained channel always reloads its base value.
- R9: Control bits [7:4] are per-channel masks. A set mask bit suppresses that channel's interrupt line while counting, reload and toggle carry on.
- R10: The frequency register reads back what was written and has no effect on step timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Word address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq | output | 4 | Per-channel interrupt request, one-cycle pulse per event |

## Verification
A register write commits on the edge where the strobe is sampled, and read data reflects it right after that edge. A stop-flag release loads the count one edge later. The interrupt for a zero event rises on the very edge of the step that found the count at zero. The bench therefore computes each step edge from the control-write edge and the ratio, and the base-write edge from the base value. It queues the absolute cycle at which each interrupt must appear, and the monitor compares those cycles one by one against the line seen between edges. Channels are stopped by a write timed so that the bench knows exactly which events still land before the stop takes hold.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;

    // Which register class a bus address selects.
    typedef enum logic [2:0] {
        RS_BASE,
        RS_COUNT,
        RS_CTRL,
        RS_FREQ,
        RS_NONE
    } reg_sel_e;

endpackage

// File: rtl/tmr_bank_tick.sv
// Shared step generator: one step every ratio+1 clocks, phase restartable.
module tmr_bank_tick #(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [RW-1:0] ratio,
    output logic          tick
);

    typedef struct packed {
        logic [RW-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt >= ratio);
        if (restart || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tmr_bank_chan.sv
// One down-counting channel with release load, reload, toggle and interrupt pulse.
module tmr_bank_chan #(
    parameter int CW = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          inhibit,
    input  logic          reload_ones,
    input  logic          mask,
    input  logic [CW-1:0] base,
    output logic [CW-1:0] count,
    output logic          toggle,
    output logic          zero,
    output logic          irq
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tog;
        logic          inh_prev;
        logic          irq;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     release_w;

    always_comb begin
        st_d          = st_q;
        st_d.inh_prev = inhibit;
        st_d.irq      = 1'b0;
        release_w     = st_q.inh_prev & ~inhibit;
        zero          = step & ~inhibit & ~release_w & (st_q.cnt == '0);
        if (release_w) begin
            st_d.cnt = base;
            st_d.tog = 1'b0;
        end else if (step && !inhibit) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = reload_ones ? '1 : base;
                st_d.tog = ~st_q.tog;
                st_d.irq = ~mask;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt      <= '0;
            st_q.tog      <= 1'b0;
            st_q.inh_prev <= 1'b1;
            st_q.irq      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count  = st_q.cnt;
    assign toggle = st_q.tog;
    assign irq    = st_q.irq;

endmodule

// File: rtl/tmr_bank.sv
// Timer bank top: register file, prescaler and a chain of channels.
module tmr_bank #(
    parameter int NCH = 4,
    parameter int DW  = 32,
    parameter int AW  = 4,
    parameter int RW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    output logic [NCH-1:0] irq
);
    import tmr_bank_pkg::*;

    localparam int CW        = DW - 1;
    localparam int CHW       = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int CTRL_IDX  = 2 * NCH;
    localparam int FREQ_IDX  = 2 * NCH + 1;
    localparam int ROVR_BIT  = NCH - 1;
    localparam int MASK_LSB  = NCH;
    localparam int RATIO_LSB = 2 * NCH;

    typedef struct packed {
        logic [NCH-1:0]         inh;
        logic [NCH-1:0][CW-1:0] base;
        logic [NCH-2:0]         casc;
        logic                   rovr;
        logic [NCH-1:0]         mask;
        logic [RW-1:0]          ratio;
        logic [DW-1:0]          freq;
    } regs_t;

    regs_t                  regs_d, regs_q;
    reg_sel_e               sel;
    logic [CHW-1:0]         ch;
    logic                   restart;
    logic                   tick;
    logic [NCH-1:0][CW-1:0] cnt_w;
    logic [NCH-1:0]         tog_w;

    // Plain views of register state for the bound checker.
    logic [NCH-1:0]         inh_v;
    logic [NCH-1:0][CW-1:0] base_v;
    logic [NCH-1:0]         mask_v;

    // Address decode.
    always_comb begin
        int a;
        a   = int'(addr);
        sel = RS_NONE;
        ch  = '0;
        if (a < NCH) begin
            sel = RS_BASE;
            ch  = CHW'(a);
        end else if (a < 2 * NCH) begin
            sel = RS_COUNT;
            ch  = CHW'(a - NCH);
        end else if (a == CTRL_IDX) begin
            sel = RS_CTRL;
        end else if (a == FREQ_IDX) begin
            sel = RS_FREQ;
        end
    end

    // Next-state of the register file.
    always_comb begin
        regs_d  = regs_q;
        restart = 1'b0;
        if (wr_en) begin
            unique case (sel)
                RS_BASE: begin
                    regs_d.inh[ch]  = wdata[0];
                    regs_d.base[ch] = wdata[DW-1:1];
                end
                RS_CTRL: begin
                    regs_d.casc  = wdata[NCH-2:0];
                    regs_d.rovr  = wdata[ROVR_BIT];
                    regs_d.mask  = wdata[MASK_LSB +: NCH];
                    regs_d.ratio = wdata[RATIO_LSB +: RW];
                    restart      = 1'b1;
                end
                RS_FREQ: regs_d.freq = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q     <= '0;
            regs_q.inh <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    // Read mux.
    always_comb begin
        rdata = '0;
        unique case (sel)
            RS_BASE:  rdata = {regs_q.base[ch], regs_q.inh[ch]};
            RS_COUNT: rdata = {cnt_w[ch], tog_w[ch]};
            RS_CTRL: begin
                rdata[NCH-2:0]              = regs_q.casc;
                rdata[ROVR_BIT]             = regs_q.rovr;
                rdata[MASK_LSB +: NCH]      = regs_q.mask;
                rdata[RATIO_LSB +: RW]      = regs_q.ratio;
            end
            RS_FREQ:  rdata = regs_q.freq;
            default:  rdata = '0;
        endcase
    end

    tmr_bank_tick #(.RW(RW)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .ratio   (regs_q.ratio),
        .tick    (tick)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic step_i;
        logic ones_i;
        logic zero_i;
        logic [CW-1:0] cnt_i;
        logic tog_i;

        if (i == 0) begin : g_head
            assign step_i = tick;
            assign ones_i = 1'b0;
        end else begin : g_link
            assign step_i = regs_q.casc[i-1] ? g_ch[i-1].zero_i : tick;
            assign ones_i = regs_q.casc[i-1] & regs_q.rovr;
        end

        tmr_bank_chan #(.CW(CW)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .step        (step_i),
            .inhibit     (regs_q.inh[i]),
            .reload_ones (ones_i),
            .mask        (regs_q.mask[i]),
            .base        (regs_q.base[i]),
            .count       (cnt_i),
            .toggle      (tog_i),
            .zero        (zero_i),
            .irq         (irq[i])
        );

        assign cnt_w[i] = cnt_i;
        assign tog_w[i] = tog_i;
    end

    assign inh_v  = regs_q.inh;
    assign base_v = regs_q.base;
    assign mask_v = regs_q.mask;

endmodule

// File: rtl/tmr_bank_check.sv
// Temporal checks on the timer bank, attached by bind.
module tmr_bank_check #(
    parameter int NCH = 4,
    parameter int CW  = 31
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NCH-1:0]         inh,
    input logic [NCH-1:0][CW-1:0] base,
    input logic [NCH-1:0][CW-1:0] cnt,
    input logic [NCH-1:0]         tog,
    input logic [NCH-1:0]         mask,
    input logic [NCH-1:0]         irq
);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R3: a stopped channel keeps count and toggle
        a_r3_hold_when_stopped: assert property (
            @(posedge clk) disable iff (!rst_n)
            inh[i] |=> ($stable(cnt[i]) && $stable(tog[i])));

        // R3: no interrupt unless the channel was running
        a_r3_irq_needs_run: assert property (
            @(posedge clk) disable iff (!rst_n)
            irq[i] |-> !$past(inh[i]));

        // R4: release loads base and clears toggle
        a_r4_release_load: assert property (
            @(posedge clk) disable iff (!rst_n)
            (!inh[i] && $past(inh[i])) |=> (cnt[i] == $past(base[i]) && !tog[i]));

        // R5: every interrupt comes with a toggle flip
        a_r5_irq_flips_toggle: assert property (
            @(posedge clk) disable iff (!rst_n)
            irq[i] |-> (tog[i] != $past(tog[i])));

        // R9: a masked channel raises no interrupt
        a_r9_masked_quiet: assert property (
            @(posedge clk) disable iff (!rst_n)
            irq[i] |-> !$past(mask[i]));
    end

endmodule

bind tmr_bank tmr_bank_check #(.NCH(NCH), .CW(CW)) u_check (
    .clk   (clk),
    .rst_n (rst_n),
    .inh   (inh_v),
    .base  (base_v),
    .cnt   (cnt_w),
    .tog   (tog_w),
    .mask  (mask_v),
    .irq   (irq)
);

// File: tb/sim_tmr_bank.sv
module sim_tmr_bank;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr  = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq;

    tmr_bank u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    always #2 clk = ~clk;

    int cyc      = 0;
    int n_chk    = 0;
    int n_bad    = 0;
    int seen_irq = 0;
    bit done     = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int       at;
        logic [3:0] vec;
        string    req;
    } exp_t;

    exp_t sb[$];

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every interrupt seen between edges.
    always @(negedge clk) begin : mon
        exp_t e;
        if (rst_n && irq != 4'b0) begin
            seen_irq++;
            if (sb.size() == 0) begin
                n_chk++;
                n_bad++;
                $display("FAIL R5/R9 unexpected irq: actual %b at cycle %0d expected none",
                         irq, cyc);
            end else begin
                e = sb.pop_front();
                check(e.req, 32'(cyc), 32'(e.at), "irq cycle");
                check(e.req, {28'd0, irq}, {28'd0, e.vec}, "irq lines");
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d, output int at);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        at    = cyc;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic rd_check(input string req, input logic [3:0] a,
                            input logic [31:0] exp, input string what);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp, what);
    endtask

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic drain(input string req);
        repeat (4) @(negedge clk);
        n_chk++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL %s missing irq: actual none expected %0d more at cycle %0d",
                     req, sb.size(), sb[0].at);
            sb.delete();
        end
    endtask

    // Driver: start one channel, queue its events, stop it at a known edge.
    task automatic run_single(input int ch, input int b, input int r,
                              input bit masked, input int nev, input string req);
        int c, w, s, n, first, p, last, st, stp, evs, seen0;
        logic [31:0] v;
        wr(4'd8, (masked ? (32'd1 << (4 + ch)) : 32'd0) | (32'(r) << 8), c);
        wr(4'(ch), 32'(b) << 1, w);
        @(negedge clk);
        rd_check("R4", 4'(4 + ch), 32'(b) << 1, "count loaded, toggle clear on release");
        n = 0;
        s = w + 1;
        while (n < b + 1) begin
            s++;
            if (((s - c) % (r + 1)) == 0) n++;
        end
        first = s;
        p     = (b + 1) * (r + 1);
        last  = first + (nev - 1) * p;
        st    = last + 1;
        evs   = 0;
        seen0 = seen_irq;
        for (int e = first; e <= st; e += p) begin
            evs++;
            if (!masked) sb.push_back('{e, 4'(1 << ch), req});
        end
        wait_cyc(last);
        wr(4'(ch), (32'(b) << 1) | 32'd1, stp);
        drain(req);
        if (masked) check("R9", 32'(seen_irq - seen0), 32'd0, "irq pulses while masked");
        rd(4'(4 + ch), v);
        check("R5", {31'd0, v[0]}, 32'(evs % 2), "toggle parity after events");
    endtask

    task automatic run_cascade(input bit rovr);
        int c, w0, w1, e1, s, t;
        logic [31:0] ctrl;
        ctrl = 32'd1 | (32'(rovr) << 3) | (32'd1 << 4);
        wr(4'd8, ctrl, c);
        rd_check("R7", 4'd8, ctrl, "control readback");
        wr(4'd1, 32'd1 << 1, w1);
        wr(4'd0, 32'd2 << 1, w0);
        e1 = w0 + 2 + 2 + 1 * (2 + 1);
        sb.push_back('{e1, 4'b0010, "R7"});
        wait_cyc(e1);
        wr(4'd0, (32'd2 << 1) | 32'd1, s);
        drain("R7");
        rd_check("R8", 4'd5, rovr ? 32'hFFFF_FFFF : 32'd3, "chained reload value");
        wr(4'd1, (32'd1 << 1) | 32'd1, t);
    endtask

    initial begin : main
        int w, s;
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 4; i++) rd_check("R1", 4'(i), 32'd1, "base after reset");
        for (int i = 4; i < 8; i++) rd_check("R1", 4'(i), 32'd0, "count after reset");
        rd_check("R1", 4'd8, 32'd0, "control after reset");
        rd_check("R1", 4'd9, 32'd0, "frequency after reset");
        check("R1", {28'd0, irq}, 32'd0, "irq after reset");

        // R2: unmapped address
        rd_check("R2", 4'd12, 32'd0, "unmapped read");

        // R3: decrement then hold
        wr(4'd8, 32'd0, w);
        wr(4'd1, 32'd10 << 1, w);
        @(negedge clk);
        rd_check("R4", 4'd5, 32'd10 << 1, "count after release");
        repeat (3) @(negedge clk);
        rd_check("R3", 4'd5, 32'd7 << 1, "count after three steps");
        wr(4'd1, (32'd10 << 1) | 32'd1, s);
        rd_check("R3", 4'd5, 32'd6 << 1, "count on stop edge");
        repeat (5) @(negedge clk);
        rd_check("R3", 4'd5, 32'd6 << 1, "count held while stopped");

        // R2: count register ignores writes; base reads back
        wr(4'd5, 32'hDEAD_BEEF, w);
        rd_check("R2", 4'd5, 32'd6 << 1, "count after write attempt");
        rd_check("R2", 4'd1, (32'd10 << 1) | 32'd1, "base readback");

        // R5: plain reload, several periods
        run_single(0, 4, 0, 1'b0, 3, "R5");
        // R9: masked run leaves odd toggle, then R4 clears it on release
        run_single(0, 2, 0, 1'b1, 3, "R9");
        run_single(0, 1, 0, 1'b0, 2, "R4");
        // R5: base 0 fires on every step
        run_single(3, 0, 0, 1'b0, 4, "R5");

        // R10: frequency storage with no timing effect
        wr(4'd9, 32'hA5A5_0F0F, w);
        rd_check("R10", 4'd9, 32'hA5A5_0F0F, "frequency readback");
        run_single(1, 2, 0, 1'b0, 2, "R10");

        // R6: prescaler ratio
        run_single(2, 3, 2, 1'b0, 2, "R6");
        run_single(1, 0, 4, 1'b0, 3, "R6");
        wr(4'd8, 32'd3 << 8, w);
        rd_check("R6", 4'd8, 32'd3 << 8, "ratio field readback");

        // R7 / R8: chaining with both reload choices
        run_cascade(1'b1);
        run_cascade(1'b0);

        rd(4'd0, v);
        check("R8", {31'd0, v[0]}, 32'd1, "channel 0 stopped after chain test");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule